// File: doc/BRIEF.md
# Repetition-Tested Entropy Holding Register

This block sits behind a debiasing stage and collects conditioned entropy bits one per strobe. It packs them into 16-bit blocks and runs a continuous repetition test on each finished block: a block identical to the block finished just before it is thrown away and reported as a one-cycle failure event. Blocks that pass fill a 192-bit holding register, twelve blocks in order. Once the register is full, a ready flag rises and the contents stay frozen until software clears the collection counter.

The holding register is exposed as six 32-bit words packed into one flat port. Software reads them after the ready flag rises. A bypass input turns the repetition test off. A clear request restarts collection, but it is honoured only while the entropy source is switched off, so a clear cannot race a running collection.

Top module: `rep_tested_holder`

## Requirements
- R1: After reset, `dataReady`, `repFail` and all 192 bits of `holdWords` are 0.
- R2: A bit is taken on a clock edge only when `srcEnable`, `bitValid` are 1 and `dataReady` is 0. The first bit taken in a block becomes bit 0 of that block and the sixteenth becomes bit 15.
- R3: When a block's sixteenth bit is taken and the block equals the previously finished block, `repFail` is 1 for exactly the next cycle. The block is not stored, and the next block goes into the same slot.
- R4: The first block finished after reset has no predecessor and is always stored.
- R5: While `testBypass` is 1 at the edge that finishes a block, that block is stored even if it repeats its predecessor, and `repFail` stays 0.
- R6: Accepted block n (n = 0..11) is stored at `holdWords[16n+15:16n]`, so word k occupies `holdWords[32k+31:32k]`. Word 0 is bits 31:0 and word 5 is bits 191:160.
- R7: `dataReady` becomes 1 on the edge that stores the twelfth accepted block.
- R8: While `dataReady` is 1, incoming bits are ignored and `holdWords` does not change.
- R9: `cntClear` with `srcEnable` 0 clears `dataReady` and the collected-bit count, including a partly built block, so the next block goes whole into slot 0. With `srcEnable` 1, `cntClear` has no effect.
- R10: `busy` equals `srcEnable` AND NOT `dataReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitIn | input | 1 | Conditioned entropy bit |
| bitValid | input | 1 | Strobe: bitIn is valid this cycle |
| testBypass | input | 1 | 1 disables the repetition comparison |
| srcEnable | input | 1 | Entropy source enabled |
| cntClear | input | 1 | Clear request for the collection count and ready flag |
| holdWords | output | 192 | Holding register, word k at bits 32k+31:32k |
| dataReady | output | 1 | 192 accepted bits are held |
| busy | output | 1 | Collection is in progress |
| repFail | output | 1 | One-cycle pulse when a repeated block is rejected |

## Verification
The bench sends back-to-back identical blocks and checks three things: the failure pulse, that the rejected block is not stored, and that the following block lands in the slot the rejected one would have used. A design that stored the duplicate would shift every later block up one slot. It also sends an identical block with bypass set, where a broken design would pulse a failure or drop the data. The very first block is checked as well, since a design that compares it against a reset-zero reference would reject an all-zero block. Further checks cover a clear issued mid-block and a clear issued while the source is on. The first would leave a stale bit count and misalign the next block. The second would wrongly drop ready data. Random bit streams with gaps in the strobe fill the register, and the words must then stay frozen while more bits arrive.

// File: rtl/rth_pkg.sv
package rth_pkg;
  localparam int unsigned BLOCK_BITS = 16;
  localparam int unsigned HOLD_BITS  = 192;
  localparam int unsigned WORD_BITS  = 32;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic shiftEn;   // take bitIn into the block shifter
    logic refLoad;   // finished block becomes the comparison reference
    logic storeEn;   // finished block is written into the holding register
  } rth_strobe_t;
endpackage

// File: rtl/rth_dpath.sv
module rth_dpath #(
  parameter int unsigned BLOCK_W = rth_pkg::BLOCK_BITS,
  parameter int unsigned HOLD_W  = rth_pkg::HOLD_BITS,
  localparam int unsigned NUM_BLK = HOLD_W / BLOCK_W,
  localparam int unsigned SLOT_W  = $clog2(NUM_BLK)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    bitIn,
  input  rth_pkg::rth_strobe_t    stb,
  input  logic [SLOT_W-1:0]       slot,
  output logic                    sameAsPrev,
  output logic [HOLD_W-1:0]       holdQ
);
  logic [BLOCK_W-1:0] shiftQ;
  logic [BLOCK_W-1:0] prevQ;
  logic [BLOCK_W-1:0] doneBlk;

  // New bit enters at the top, so the first bit ends at position 0.
  assign doneBlk    = {bitIn, shiftQ[BLOCK_W-1:1]};
  assign sameAsPrev = (doneBlk == prevQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      prevQ  <= '0;
    end else begin
      if (stb.shiftEn) shiftQ <= doneBlk;
      if (stb.refLoad) prevQ  <= doneBlk;
    end
  end

  for (genvar g = 0; g < NUM_BLK; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        holdQ[g*BLOCK_W +: BLOCK_W] <= '0;
      end else if (stb.storeEn && (slot == SLOT_W'(g))) begin
        holdQ[g*BLOCK_W +: BLOCK_W] <= doneBlk;
      end
    end
  end
endmodule

// File: rtl/rth_ctrl.sv
module rth_ctrl #(
  parameter int unsigned BLOCK_W = rth_pkg::BLOCK_BITS,
  parameter int unsigned HOLD_W  = rth_pkg::HOLD_BITS,
  localparam int unsigned NUM_BLK = HOLD_W / BLOCK_W,
  localparam int unsigned SLOT_W  = $clog2(NUM_BLK),
  localparam int unsigned POS_W   = $clog2(BLOCK_W)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    bitValid,
  input  logic                    testBypass,
  input  logic                    srcEnable,
  input  logic                    cntClear,
  input  logic                    sameAsPrev,
  output rth_pkg::rth_strobe_t    stb,
  output logic [SLOT_W-1:0]       slot,
  output logic                    readyQ,
  output logic                    failQ
);
  logic [POS_W-1:0]  bitPos;
  logic [SLOT_W-1:0] slotIdx;
  logic              havePrev;
  logic              take;
  logic              lastBit;
  logic              reject;
  logic              clrReq;

  assign take    = srcEnable && bitValid && !readyQ;
  assign lastBit = take && (bitPos == POS_W'(BLOCK_W - 1));
  assign reject  = lastBit && havePrev && !testBypass && sameAsPrev;
  assign clrReq  = cntClear && !srcEnable;

  assign stb.shiftEn = take;
  assign stb.refLoad = lastBit;
  assign stb.storeEn = lastBit && !reject;
  assign slot        = slotIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitPos   <= '0;
      slotIdx  <= '0;
      havePrev <= 1'b0;
      readyQ   <= 1'b0;
      failQ    <= 1'b0;
    end else begin
      failQ <= 1'b0;
      if (clrReq) begin
        bitPos  <= '0;
        slotIdx <= '0;
        readyQ  <= 1'b0;
      end
      if (take) begin
        if (lastBit) begin
          bitPos   <= '0;
          havePrev <= 1'b1;
          if (reject) begin
            failQ <= 1'b1;
          end else if (slotIdx == SLOT_W'(NUM_BLK - 1)) begin
            readyQ  <= 1'b1;
            slotIdx <= '0;
          end else begin
            slotIdx <= slotIdx + 1'b1;
          end
        end else begin
          bitPos <= bitPos + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rep_tested_holder.sv
module rep_tested_holder #(
  parameter int unsigned BLOCK_W = rth_pkg::BLOCK_BITS,
  parameter int unsigned HOLD_W  = rth_pkg::HOLD_BITS,
  localparam int unsigned NUM_BLK = HOLD_W / BLOCK_W,
  localparam int unsigned SLOT_W  = $clog2(NUM_BLK)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitIn,
  input  logic              bitValid,
  input  logic              testBypass,
  input  logic              srcEnable,
  input  logic              cntClear,
  output logic [HOLD_W-1:0] holdWords,
  output logic              dataReady,
  output logic              busy,
  output logic              repFail
);
  rth_pkg::rth_strobe_t stb;
  logic [SLOT_W-1:0]    slot;
  logic                 sameAsPrev;

  rth_ctrl #(.BLOCK_W(BLOCK_W), .HOLD_W(HOLD_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .testBypass(testBypass),
    .srcEnable(srcEnable), .cntClear(cntClear), .sameAsPrev(sameAsPrev),
    .stb(stb), .slot(slot), .readyQ(dataReady), .failQ(repFail)
  );

  rth_dpath #(.BLOCK_W(BLOCK_W), .HOLD_W(HOLD_W)) dpath_i (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .stb(stb), .slot(slot),
    .sameAsPrev(sameAsPrev), .holdQ(holdWords)
  );

  assign busy = srcEnable && !dataReady;
endmodule

// File: rtl/rth_checker.sv
module rth_checker #(
  parameter int unsigned HOLD_W = rth_pkg::HOLD_BITS
) (
  input logic              clk,
  input logic              rstN,
  input logic              bitValid,
  input logic              testBypass,
  input logic              srcEnable,
  input logic              cntClear,
  input logic [HOLD_W-1:0] holdWords,
  input logic              dataReady,
  input logic              busy,
  input logic              repFail
);
  AST_FAIL_SINGLE: assert property (@(posedge clk) disable iff (!rstN) repFail |=> !repFail); // R3
  AST_FAIL_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rstN) repFail |-> $past(srcEnable && bitValid)); // R3
  AST_BYPASS_NO_FAIL: assert property (@(posedge clk) disable iff (!rstN) repFail |-> !$past(testBypass)); // R5
  AST_READY_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rstN) $rose(dataReady) |-> $past(srcEnable && bitValid)); // R7
  AST_READY_FROZEN: assert property (@(posedge clk) disable iff (!rstN) dataReady |=> $stable(holdWords)); // R8
  AST_READY_NO_FAIL: assert property (@(posedge clk) disable iff (!rstN) dataReady |=> !repFail); // R8
  AST_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rstN) (cntClear && !srcEnable) |=> !dataReady); // R9
  AST_CLEAR_ON_NOP: assert property (@(posedge clk) disable iff (!rstN) (cntClear && srcEnable && dataReady) |=> dataReady); // R9
  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rstN) dataReady |-> !busy); // R10
endmodule

bind rep_tested_holder rth_checker #(.HOLD_W(HOLD_W)) chk_i (
  .clk(clk), .rstN(rstN), .bitValid(bitValid), .testBypass(testBypass),
  .srcEnable(srcEnable), .cntClear(cntClear), .holdWords(holdWords),
  .dataReady(dataReady), .busy(busy), .repFail(repFail)
);

// File: tb/rep_tested_holder_tb.sv
module rep_tested_holder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 16;
  localparam int HW = 192;
  localparam int NB = HW / BW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitIn = 1'b0, bitValid = 1'b0, testBypass = 1'b0, srcEnable = 1'b0, cntClear = 1'b0;
  logic [HW-1:0] holdWords;
  logic dataReady, busy, repFail;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // reference model state
  logic [BW-1:0] mShift, mPrev;
  logic [HW-1:0] mHold;
  int mPos, mIdx;
  bit mHave, mReady, mFail;

  always #(CLK_PERIOD/2) clk = ~clk;

  rep_tested_holder dut_i (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid),
    .testBypass(testBypass), .srcEnable(srcEnable), .cntClear(cntClear),
    .holdWords(holdWords), .dataReady(dataReady), .busy(busy), .repFail(repFail)
  );

  function automatic logic [31:0] wordOf(input logic [HW-1:0] v, input int k);
    return v[k*32 +: 32];
  endfunction

  function automatic bit expBusy(input bit en, input bit rdy);
    return en && !rdy;
  endfunction

  task automatic check(input string tag, input logic [HW-1:0] act, input logic [HW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check({tag, " ready"}, HW'(dataReady), HW'(mReady));
    check({tag, " fail"}, HW'(repFail), HW'(mFail));
    check("R10 busy", HW'(busy), HW'(expBusy(srcEnable, mReady)));
    check({tag, " hold"}, holdWords, mHold);
  endtask

  // Drive one cycle at the falling edge, update the model, sample at the next falling edge.
  task automatic step(input bit v, input bit b, input bit en, input bit byp, input bit clr, input string tag);
    logic [BW-1:0] blk;
    bitValid = v; bitIn = b; srcEnable = en; testBypass = byp; cntClear = clr;
    mFail = 1'b0;
    if (clr && !en) begin mPos = 0; mIdx = 0; mReady = 1'b0; end
    if (en && v && !mReady) begin
      blk = {b, mShift[BW-1:1]};
      mShift = blk;
      if (mPos == BW - 1) begin
        mPos = 0;
        if (mHave && !byp && blk == mPrev) begin
          mFail = 1'b1;
        end else begin
          mHold[mIdx*BW +: BW] = blk;
          if (mIdx == NB - 1) begin mReady = 1'b1; mIdx = 0; end
          else mIdx++;
        end
        mPrev = blk; mHave = 1'b1;
      end else begin
        mPos++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    checkAll(tag);
  endtask

  task automatic sendBlock(input logic [BW-1:0] val, input bit byp, input bit gappy, input string tag);
    for (int i = 0; i < BW; i++) begin
      if (gappy && ($urandom % 3 == 0)) step(1'b0, 1'b1, 1'b1, byp, 1'b0, tag);
      step(1'b1, val[i], 1'b1, byp, 1'b0, tag);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [HW-1:0] snap;
    logic [BW-1:0] rb;
    void'($urandom(32'd1234));
    mShift = '0; mPrev = '0; mHold = '0; mPos = 0; mIdx = 0;
    mHave = 1'b0; mReady = 1'b0; mFail = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 ready", HW'(dataReady), '0);
    check("R1 fail", HW'(repFail), '0);
    check("R1 hold", holdWords, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: bits ignored while the source is off
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2 disabled");
    // R4: first block all zero, compared with nothing, stored
    sendBlock(16'h0000, 1'b0, 1'b0, "R4 first");
    check("R4 slot0", HW'(holdWords[15:0]), HW'(16'h0000));
    check("R4 nofail", HW'(repFail), '0);
    // R2/R6: bit order inside a block, slot 1
    sendBlock(16'hA5C3, 1'b0, 1'b1, "R2 order");
    check("R6 slot1", HW'(holdWords[31:16]), HW'(16'hA5C3));
    // R3: repeat rejected, pulse after the last bit
    sendBlock(16'hA5C3, 1'b0, 1'b0, "R3 repeat");
    check("R3 pulse", HW'(repFail), HW'(1'b1));
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R3 pulse end");
    check("R3 pulse one cycle", HW'(repFail), '0);
    sendBlock(16'h1E0F, 1'b0, 1'b0, "R3 next slot");
    check("R3 same slot", HW'(holdWords[47:32]), HW'(16'h1E0F));
    // R5: bypass keeps a repeated block
    sendBlock(16'h1E0F, 1'b1, 1'b0, "R5 bypass");
    check("R5 stored", HW'(holdWords[63:48]), HW'(16'h1E0F));
    check("R5 nofail", HW'(repFail), '0);

    // R7/R6: random fill with some deliberate repeats
    for (int n = 0; n < 40 && !mReady; n++) begin
      if ($urandom % 3 == 0) rb = mPrev;
      else rb = BW'($urandom);
      sendBlock(rb, 1'b0, 1'b1, "R7 random");
    end
    check("R7 ready", HW'(dataReady), HW'(1'b1));
    for (int k = 0; k < 6; k++) check("R6 word", HW'(wordOf(holdWords, k)), HW'(wordOf(mHold, k)));

    // R8: frozen while ready
    snap = holdWords;
    for (int i = 0; i < 40; i++) step(1'b1, i[0] ^ i[2], 1'b1, 1'b0, 1'b0, "R8 frozen");
    check("R8 hold", holdWords, snap);
    // R9: clear while source on is ignored
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R9 clear on");
    check("R9 still ready", HW'(dataReady), HW'(1'b1));
    // R10: busy low with source off
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 off");
    check("R10 busy off", HW'(busy), '0);
    // R9: clear while off
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R9 clear off");
    check("R9 cleared", HW'(dataReady), '0);
    check("R10 busy on", HW'(busy), '0);
    // R9: partial block discarded by clear
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R9 partial");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R9 clear partial");
    sendBlock(16'h6B29, 1'b0, 1'b1, "R9 realign");
    check("R9 slot0", HW'(holdWords[15:0]), HW'(16'h6B29));
    check("R10 busy collecting", HW'(busy), HW'(1'b1));

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule